// File: doc/BRIEF.md
# In-Place Radix-2 FFT Engine

This block computes a complex discrete Fourier transform over a frame of `NPTS` points (1024 by default), held in one working memory of 32-bit words. Each word packs a signed 16-bit real part in its upper half and a signed 16-bit imaginary part in its lower half. One butterfly datapath is shared by every operation. A stage and butterfly sequencer walks it through all log2(NPTS) stages. For each butterfly it reads two operands and one twiddle factor, then writes both results back in place.

Each frame runs in three phases. In the fill phase, samples arrive through a valid/ready handshake and are stored at bit-reversed addresses. The compute phase follows. In the drain phase, results leave in natural frequency order through a second valid/ready handshake. Every stage halves its results, so the output is the transform divided by `NPTS`, and a full-scale frame cannot overflow.

Two unrelated real signals can share one transform: place one in the real half and the other in the imaginary half. Separating the two spectra afterwards is left to the user.

Top module: `fftx_core`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0.
- R2: A sample is taken on each rising edge where `in_valid` and `in_ready` are both 1. Bits [31:16] of `in_data` are the signed real part and bits [15:0] the signed imaginary part. The first sample taken in a frame is time index 0, and a frame ends after `NPTS` samples.
- R3: After the edge that takes the last sample of a frame, `in_ready` stays 0. `out_valid` becomes 1 after exactly `NPTS*log2(NPTS)` further rising edges, which is 10240 for 1024 points and 384 for 64 points.
- R4: Results leave in natural order k = 0..NPTS-1, packed like the input. Each part of result k is within log2(NPTS)+2 LSB of (1/NPTS)·Σ x[n]·e^(−j2πnk/NPTS).
- R5: Each stage divides by two exactly where no rounding is involved. A frame whose sample 0 is (A, 0), with A a multiple of `NPTS` and all other samples zero, gives (A/NPTS, 0) exactly in every bin.
- R6: Full-scale inputs never wrap. A constant frame of (32767, −32768) gives bin 0 with a positive real part and a negative imaginary part, with every bin within the R4 tolerance.
- R7: `in_valid` and `in_data` presented while `in_ready` is 0 have no effect. The current and the next frame's results are unchanged.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold steady. Each edge with both at 1 advances to the next bin.
- R9: On the cycle after the handshake that takes the last result, `in_ready` is 1. A sample already held valid during the drain is taken on that cycle as sample 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine is in the fill phase and takes samples |
| in_data | input | 32 | Sample: real part [31:16], imaginary part [15:0] |
| out_valid | output | 1 | A result bin is presented |
| out_ready | input | 1 | Consumer takes the presented bin |
| out_data | output | 32 | Result bin: real part [31:16], imaginary part [15:0] |

## Verification
The final output handshake of one frame can land in the same cycle as the first input offer of the next frame. This is provoked by holding the next frame's sample 0 valid for the whole drain. The bench then checks that `in_ready` rises on the cycle after the last handshake, that the held sample is taken only then, and that the following frame's spectrum matches its reference. Input offered during the compute phase is a second overlap; garbage is driven there to show it is ignored. A stalled drain with `out_ready` low shows that a held bin does not move.

// File: rtl/fftx_pkg.sv
package fftx_pkg;

    typedef struct packed {
        logic signed [15:0] re;
        logic signed [15:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_CALC  = 2'd1,
        PH_DRAIN = 2'd2
    } phase_t;

    // Clamp an 18-bit signed value into the 16-bit signed range.
    function automatic logic signed [15:0] clip16(input logic signed [17:0] v);
        if (v > 18'sd32767)  return 16'sh7fff;
        if (v < -18'sd32768) return 16'sh8000;
        return v[15:0];
    endfunction

    // Mirror the low w bits of v (w <= 32).
    function automatic logic [31:0] rev_bits(input logic [31:0] v, input int w);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < w; i++) r[w-1-i] = v[i];
        return r;
    endfunction

    // Q15 twiddle exp(-j*2*pi*k/n), scaled by 32767.
    function automatic cplx_t twiddle(input int k, input int n);
        real   ang;
        cplx_t t;
        ang  = 6.283185307179586 * real'(k) / real'(n);
        t.re = 16'(int'($cos(ang) * 32767.0));
        t.im = 16'(-int'($sin(ang) * 32767.0));
        return t;
    endfunction

endpackage

// File: rtl/fftx_twrom.sv
module fftx_twrom
    import fftx_pkg::*;
#(
    parameter  int NPTS = 1024,
    localparam int HALF = NPTS / 2,
    localparam int AW   = $clog2(HALF)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    output cplx_t         q
);
    cplx_t tab [HALF];

    initial begin
        for (int k = 0; k < HALF; k++) tab[k] = twiddle(k, NPTS);
    end

    always_ff @(posedge clk) q <= tab[addr];
endmodule

// File: rtl/fftx_ram.sv
module fftx_ram
    import fftx_pkg::*;
#(
    parameter  int NPTS = 1024,
    localparam int AW   = $clog2(NPTS)
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] ad_a,
    input  cplx_t         wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] ad_b,
    input  cplx_t         wd_b,
    output cplx_t         rq_a,
    output cplx_t         rq_b,
    input  logic [AW-1:0] ad_x,
    output cplx_t         rq_x
);
    cplx_t mem [NPTS];

    always_ff @(posedge clk) begin
        if (we_a) mem[ad_a] <= wd_a;
        if (we_b) mem[ad_b] <= wd_b;
        rq_a <= mem[ad_a];
        rq_b <= mem[ad_b];
    end

    assign rq_x = mem[ad_x];
endmodule

// File: rtl/fftx_agen.sv
module fftx_agen #(
    parameter  int L   = 10,
    parameter  int SW  = 4,
    localparam int LM1 = L - 1
) (
    input  logic [SW-1:0]  stg,
    input  logic [LM1-1:0] bfi,
    output logic [L-1:0]   pa,
    output logic [L-1:0]   pb,
    output logic [LM1-1:0] twa
);
    logic [L-1:0] jj, half, low;

    always_comb begin
        jj   = {1'b0, bfi};
        half = L'(1) << stg;
        low  = jj & (half - L'(1));
        pa   = ((jj >> stg) << (stg + SW'(1))) | low;
        pb   = pa | half;
        twa  = LM1'(low << (SW'(LM1) - stg));
    end
endmodule

// File: rtl/fftx_bfly.sv
module fftx_bfly
    import fftx_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  cplx_t w,
    output cplx_t c,
    output cplx_t d
);
    logic signed [31:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [32:0] acc_re, acc_im;
    logic signed [17:0] m_re, m_im;
    logic signed [18:0] s_re, s_im, t_re, t_im;

    always_comb begin
        p_rr   = 32'(b.re) * 32'(w.re);
        p_ii   = 32'(b.im) * 32'(w.im);
        p_ri   = 32'(b.re) * 32'(w.im);
        p_ir   = 32'(b.im) * 32'(w.re);
        // Round the Q15 product back to integer scale before the add.
        acc_re = 33'(p_rr) - 33'(p_ii) + 33'sd16384;
        acc_im = 33'(p_ri) + 33'(p_ir) + 33'sd16384;
        m_re   = 18'(acc_re >>> 15);
        m_im   = 18'(acc_im >>> 15);
        s_re   = 19'(a.re) + 19'(m_re);
        s_im   = 19'(a.im) + 19'(m_im);
        t_re   = 19'(a.re) - 19'(m_re);
        t_im   = 19'(a.im) - 19'(m_im);
        // One-bit downshift per stage, then clamp.
        c.re   = clip16(18'(s_re >>> 1));
        c.im   = clip16(18'(s_im >>> 1));
        d.re   = clip16(18'(t_re >>> 1));
        d.im   = clip16(18'(t_im >>> 1));
    end
endmodule

// File: rtl/fftx_core.sv
module fftx_core
    import fftx_pkg::*;
#(
    parameter int NPTS = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);
    localparam int L    = $clog2(NPTS);
    localparam int LM1  = L - 1;
    localparam int SW   = $clog2(L + 1);
    localparam int HALF = NPTS / 2;

    phase_t         ph;
    logic [L-1:0]   idx;
    logic [SW-1:0]  stg;
    logic [LM1-1:0] bfi;
    logic           wr_ph;

    logic           take, give, calc_wr, last_idx, last_bf, last_stg;
    logic [L-1:0]   pa, pb, ad_a;
    logic [LM1-1:0] twa;
    cplx_t          op_a, op_b, tw, res_c, res_d, wd_a, dump_q;

    assign in_ready  = (ph == PH_FILL);
    assign out_valid = (ph == PH_DRAIN);
    assign take      = in_valid & in_ready;
    assign give      = out_valid & out_ready;
    assign calc_wr   = (ph == PH_CALC) & wr_ph;
    assign last_idx  = (idx == L'(NPTS - 1));
    assign last_bf   = (bfi == LM1'(HALF - 1));
    assign last_stg  = (stg == SW'(LM1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_FILL;
            idx   <= '0;
            stg   <= '0;
            bfi   <= '0;
            wr_ph <= 1'b0;
        end else begin
            case (ph)
                PH_FILL: if (take) begin
                    idx <= idx + L'(1);
                    if (last_idx) begin
                        ph    <= PH_CALC;
                        stg   <= '0;
                        bfi   <= '0;
                        wr_ph <= 1'b0;
                    end
                end
                PH_CALC: begin
                    wr_ph <= ~wr_ph;
                    if (wr_ph) begin
                        bfi <= bfi + LM1'(1);
                        if (last_bf) begin
                            if (last_stg) ph <= PH_DRAIN;
                            else          stg <= stg + SW'(1);
                        end
                    end
                end
                PH_DRAIN: if (give) begin
                    idx <= idx + L'(1);
                    if (last_idx) ph <= PH_FILL;
                end
                default: ph <= PH_FILL;
            endcase
        end
    end

    fftx_agen #(.L(L), .SW(SW)) agen_i (
        .stg(stg), .bfi(bfi), .pa(pa), .pb(pb), .twa(twa)
    );

    fftx_twrom #(.NPTS(NPTS)) rom_i (.clk(clk), .addr(twa), .q(tw));

    assign ad_a = (ph == PH_FILL) ? L'(rev_bits(32'(idx), L)) : pa;
    assign wd_a = (ph == PH_FILL) ? cplx_t'(in_data) : res_c;

    fftx_ram #(.NPTS(NPTS)) ram_i (
        .clk(clk),
        .we_a(take | calc_wr), .ad_a(ad_a), .wd_a(wd_a),
        .we_b(calc_wr),        .ad_b(pb),   .wd_b(res_d),
        .rq_a(op_a), .rq_b(op_b),
        .ad_x(idx), .rq_x(dump_q)
    );

    fftx_bfly bfly_i (.a(op_a), .b(op_b), .w(tw), .c(res_c), .d(res_d));

    assign out_data = dump_q;

    // R1: reset leaves the engine open for input, with nothing presented
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R3: taking the last sample closes the input side
    a_r3_fill_closes: assert property (@(posedge clk) disable iff (rst)
        (take && last_idx) |=> !in_ready);

    // R3: results appear only straight out of the compute phase
    a_r3_drain_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(ph) == PH_CALC));

    // R4: the sequencer writes two distinct words in every butterfly
    a_r4_pair_distinct: assert property (@(posedge clk) disable iff (rst)
        calc_wr |-> (pa < pb));

    // R8: a stalled result stays put
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: the last result handshake reopens the input side
    a_r9_reopen: assert property (@(posedge clk) disable iff (rst)
        (give && last_idx) |=> in_ready);
endmodule

// File: tb/fftx_core_tb_top.sv
module fftx_core_tb_top;
    localparam int CLK_NS = 10;
    localparam int NB     = 64;
    localparam int LB     = 6;
    localparam int TOL    = LB + 2;
    localparam int LAT    = NB * LB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_ready = 1'b0;
    logic        in_ready, out_valid;
    logic [31:0] out_data;

    int  total = 0;
    int  bad   = 0;
    int  xr [NB];
    int  xi [NB];
    int  gr [NB];
    int  gi [NB];
    real er [NB];
    real ei [NB];
    int  seed = 7;

    always #(CLK_NS/2) clk = ~clk;

    fftx_core #(.NPTS(NB)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 16'h3fff) - 8192;
    endfunction

    task automatic ref_dft();
        for (int k = 0; k < NB; k++) begin
            real sr, si, th;
            sr = 0.0;
            si = 0.0;
            for (int n = 0; n < NB; n++) begin
                th = 6.283185307179586 * real'((n * k) % NB) / real'(NB);
                sr += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
                si += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
            end
            er[k] = sr / real'(NB);
            ei[k] = si / real'(NB);
        end
    endtask

    // Feed samples first..NB-1; returns right after the edge that takes the last one.
    task automatic send_frame(input int first);
        for (int n = first; n < NB; n++) begin
            @(negedge clk);
            in_data  = {16'(xr[n]), 16'(xi[n])};
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
    endtask

    // Count edges to the first result while offering garbage input (R3, R7).
    task automatic wait_result();
        int cyc;
        int opened;
        cyc    = 0;
        opened = 0;
        while (cyc < LAT + 20) begin
            @(posedge clk);
            cyc++;
            #1;
            if (in_ready) opened++;
            if (out_valid) break;
            in_valid = 1'b1;
            in_data  = 32'h5a5a_a5a5;
        end
        chk(cyc == LAT, "R3", "edges to first result", cyc, LAT);
        chk(opened == 0, "R3", "in_ready rose while busy", opened, 0);
        in_valid = 1'b0;
    endtask

    task automatic collect_frame(input bit stall, input bit pre, input int p_re, input int p_im);
        logic [31:0] held;
        in_valid = pre;
        in_data  = {16'(p_re), 16'(p_im)};
        for (int k = 0; k < NB; k++) begin
            out_ready = 1'b0;
            if (stall && (k % 7 == 3)) begin
                @(negedge clk);
                held = out_data;
                @(negedge clk);
                chk(out_valid && (out_data == held), "R8", "stalled bin moved",
                    int'(out_data), int'(held));
            end
            @(negedge clk);
            chk(out_valid, "R8", "out_valid during drain", int'(out_valid), 1);
            if (pre) chk(!in_ready, "R9", "in_ready during drain", int'(in_ready), 0);
            gr[k] = int'($signed(out_data[31:16]));
            gi[k] = int'($signed(out_data[15:0]));
            out_ready = 1'b1;
            @(posedge clk);
            #1;
        end
        out_ready = 1'b0;
        chk(in_ready == 1'b1, "R9", "in_ready after last result", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R9", "out_valid after last result", int'(out_valid), 0);
        if (pre) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic compare(input string tag, input int tol);
        for (int k = 0; k < NB; k++) begin
            real dr, di;
            dr = real'(gr[k]) - er[k];
            di = real'(gi[k]) - ei[k];
            if (dr < 0.0) dr = -dr;
            if (di < 0.0) di = -di;
            chk(dr <= real'(tol), tag, $sformatf("bin %0d real", k), gr[k], int'(er[k]));
            chk(di <= real'(tol), tag, $sformatf("bin %0d imag", k), gi[k], int'(ei[k]));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    // R5: impulse at n=0 gives a flat spectrum of exactly A/NB
    task automatic t_impulse();
        for (int n = 0; n < NB; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[0] = 16384;
        send_frame(0);
        wait_result();
        collect_frame(1'b0, 1'b0, 0, 0);
        for (int k = 0; k < NB; k++) begin
            chk(gr[k] == 16384 / NB, "R5", $sformatf("bin %0d real", k), gr[k], 16384 / NB);
            chk(gi[k] == 0, "R5", $sformatf("bin %0d imag", k), gi[k], 0);
        end
    endtask

    // R2: impulse at n=1 exposes sample order and output order
    task automatic t_shifted_impulse();
        for (int n = 0; n < NB; n++) begin xr[n] = 0; xi[n] = 0; end
        xr[1] = 12800;
        ref_dft();
        send_frame(0);
        wait_result();
        collect_frame(1'b0, 1'b0, 0, 0);
        compare("R2", TOL);
    endtask

    // R4: two real signals packed in the real and imaginary halves
    task automatic t_two_tones();
        for (int n = 0; n < NB; n++) begin
            real th;
            th    = 6.283185307179586 * real'(n) / real'(NB);
            xr[n] = int'(8000.0 * $cos(3.0 * th));
            xi[n] = int'(6000.0 * $sin(5.0 * th) + 2000.0 * $cos(11.0 * th));
        end
        ref_dft();
        send_frame(0);
        wait_result();
        collect_frame(1'b0, 1'b0, 0, 0);
        compare("R4", TOL);
    endtask

    // R6: full-scale constant frame, drained with stalls (R8)
    task automatic t_full_scale();
        for (int n = 0; n < NB; n++) begin xr[n] = 32767; xi[n] = -32768; end
        ref_dft();
        send_frame(0);
        wait_result();
        collect_frame(1'b1, 1'b0, 0, 0);
        compare("R6", TOL);
        chk(gr[0] > 0, "R6", "bin 0 real sign", gr[0], 32767);
        chk(gi[0] < 0, "R6", "bin 0 imag sign", gi[0], -32768);
    endtask

    // R9: next frame's first sample held valid across the whole drain
    task automatic t_back_to_back();
        int nr [NB];
        int ni [NB];
        for (int n = 0; n < NB; n++) begin xr[n] = rnd(); xi[n] = rnd(); end
        for (int n = 0; n < NB; n++) begin nr[n] = rnd(); ni[n] = rnd(); end
        ref_dft();
        send_frame(0);
        wait_result();
        collect_frame(1'b0, 1'b1, nr[0], ni[0]);
        compare("R4", TOL);
        for (int n = 0; n < NB; n++) begin xr[n] = nr[n]; xi[n] = ni[n]; end
        ref_dft();
        send_frame(1);
        wait_result();
        collect_frame(1'b0, 1'b0, 0, 0);
        compare("R9", TOL);
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_shifted_impulse();
        t_two_tones();
        t_full_scale();
        t_back_to_back();
        summary();
        $finish;
    end
endmodule